// File: doc/BRIEF.md
# Rate-Programmable Receive Bit Synchronizer

This block takes the raw, asynchronous bit stream from a frequency demodulator and rebuilds a clean bit clock from it. A phase accumulator runs at the nominal bit rate. The rate comes from a 6-bit exponent code, and each step of the code lowers the rate by one eighth of an octave. Every transition on the incoming stream pulls the accumulator phase toward the bit boundary. Data is captured at mid-bit. The retimed bit and a data clock that rises at the capture instant are presented to a simple host.

The loop corrects hard while it pulls in, and softly once it is tracking. The hard correction lasts for a set number of transitions, sized for an alternating preamble of twenty bits. A lock flag reports that the last few transitions all landed close to the expected boundary. A bypass mode hands the synchronized raw stream straight to the output, with no preamble needed. An inversion control flips the output data in either mode.

Top module: `rx_bitsync`

## Requirements
- R1: While reset is asserted, `data_out`, `data_clk` and `locked` are all 0 (with `invert` at 0).
- R2: With no input transitions and bypass off, `data_clk` has a period of CLK_HZ / (65574 · 2^(−n/8)) clock cycles, to within 1.5 cycles, for every code n from 0 to 63 (n = 16 gives about 16 kbit/s).
- R3: `data_clk` is high for half of its period, to within 1.5 cycles, for every code.
- R4: Outside bypass, `data_out` changes only on the clock edge where `data_clk` rises, or when `invert` changes. After that edge, its value is the input bit present at mid-bit.
- R5: An alternating 0/1 preamble of 20 bits, sent at a bit period within 2% of nominal, sets `locked` by the end of the preamble when `lock_need` is 8.
- R6: `locked` rises only after `lock_need` consecutive transitions whose phase error is below a quarter bit. A transition with an error of a quarter bit or more clears `locked` three clock edges after the input changes.
- R7: Any change of `rate_code` clears `locked` on the next clock edge and restarts acquisition.
- R8: `invert` = 1 inverts `data_out` combinationally, in both modes.
- R9: With `bypass` = 1, `data_out` equals the raw input (xor `invert`) delayed by two clock edges. `data_clk` is held at 0, and `locked` is 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 6 | Exponent code n that selects the nominal bit rate |
| bypass | input | 1 | 1 = pass the synchronized raw input straight through |
| invert | input | 1 | 1 = invert the output data |
| lock_need | input | LOCK_W | Number of consecutive in-window transitions needed for lock |
| rx_raw | input | 1 | Asynchronous demodulated data |
| data_out | output | 1 | Retimed (or bypassed) data |
| data_clk | output | 1 | Recovered bit clock; rises at the sample point |
| locked | output | 1 | Loop reports lock |

## Verification
In bypass, an input change reaches `data_out` on the second clock edge. The bench therefore checks the old value one cycle after the change and the new value two cycles after it. An input transition is seen by the loop on the third edge after it occurs, and `locked` reacts on that edge. Lock checks are therefore taken six cycles after a transition, well before the next bit boundary. A rate-code change clears `locked` one edge later, so that check comes on the next cycle. Retimed data and the clock are sampled 2 ns after each rising edge, and checked against the bit the bench is driving on every observed rise of `data_clk`. Clock periods are measured rise to rise and compared with the exponential rate law, computed in real arithmetic.

// File: rtl/rx_bitsync.sv
module rx_bitsync #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int ACC_W    = 24,
  parameter int PRE_BITS = 20,
  parameter int ACQ_SH   = 1,
  parameter int TRK_SH   = 3,
  parameter int WIN_SH   = 2,
  parameter int LOCK_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        rate_code,
  input  logic              bypass,
  input  logic              invert,
  input  logic [LOCK_W-1:0] lock_need,
  input  logic              rx_raw,
  output logic              data_out,
  output logic              data_clk,
  output logic              locked
);

  localparam int CODES = 64;
  localparam int ACQ_W = $clog2(PRE_BITS + 1);
  localparam logic [ACC_W-1:0] WIN = ACC_W'(1) << (ACC_W - WIN_SH);

  function automatic logic [ACC_W-1:0] step_for(input int code);
    longint unsigned frac, num, den;
    case (code % 8)
      0: frac = 65536;
      1: frac = 60097;
      2: frac = 55109;
      3: frac = 50535;
      4: frac = 46341;
      5: frac = 42495;
      6: frac = 38968;
      default: frac = 35734;
    endcase
    num = 64'd65574 * frac * (64'd1 << ACC_W);
    den = 64'(CLK_HZ) * 64'd65536;
    return ACC_W'((num / den) >> (code / 8));
  endfunction

  logic [ACC_W-1:0] step_rom [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_rom
    localparam logic [ACC_W-1:0] STEP = step_for(g);
    assign step_rom[g] = STEP;
  end

  logic [2:0]              sync;
  logic [ACC_W-1:0]        ph, ph_nxt, step, abs_err;
  logic signed [ACC_W-1:0] err, corr;
  logic [ACQ_W-1:0]        acq;
  logic [LOCK_W-1:0]       run, run_nxt;
  logic [5:0]              code_q;
  logic                    d_q, edge_seen, tracking, in_win, smp, restart;

  assign edge_seen = sync[1] ^ sync[2];
  assign restart   = bypass || (rate_code != code_q);
  assign tracking  = (acq == ACQ_W'(PRE_BITS));
  assign step      = step_rom[rate_code];
  assign err       = $signed(ph);
  assign abs_err   = err[ACC_W-1] ? $unsigned(-err) : $unsigned(err);
  assign in_win    = abs_err < WIN;

  always_comb begin
    corr = '0;
    if (edge_seen && !bypass)
      corr = tracking ? (err >>> TRK_SH) : (err >>> ACQ_SH);
  end

  assign ph_nxt  = ph + step - $unsigned(corr);
  assign smp     = !ph[ACC_W-1] && ph_nxt[ACC_W-1];
  assign run_nxt = (&run) ? run : run + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= '0;
      ph     <= '0;
      d_q    <= 1'b0;
      code_q <= 6'd16;
      acq    <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else begin
      sync   <= {sync[1:0], rx_raw};
      ph     <= ph_nxt;
      code_q <= rate_code;
      if (smp && !bypass)
        d_q <= sync[1];
      if (restart) begin
        acq    <= '0;
        run    <= '0;
        locked <= 1'b0;
      end else if (edge_seen) begin
        if (!tracking)
          acq <= acq + 1'b1;
        if (in_win) begin
          run <= run_nxt;
          if (run_nxt >= lock_need)
            locked <= 1'b1;
        end else begin
          run    <= '0;
          locked <= 1'b0;
        end
      end
    end
  end

  assign data_clk = ph[ACC_W-1] & ~bypass;
  assign data_out = (bypass ? sync[1] : d_q) ^ invert;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !$past(bypass) && (invert == $past(invert)) && !$rose(data_clk))
      |-> $stable(data_out));

  assert_outwin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !in_win && !restart) |=> !locked);

  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(edge_seen) && $past(in_win) && (run != '0)));

  assert_codechg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code != code_q) |=> !locked);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !locked);

endmodule

// File: tb/rx_bitsync_tb.sv
module rx_bitsync_tb;

  localparam int CLK_HZ = 500_000;
  localparam int LOCK_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] rate_code = 6'd16;
  logic bypass = 1'b0;
  logic invert = 1'b0;
  logic [LOCK_W-1:0] lock_need = 5'd8;
  logic rx_raw = 1'b0;
  logic data_out, data_clk, locked;

  int n_chk = 0;
  int n_fail = 0;
  logic mon_en = 1'b0;
  logic prev_clk = 1'b0, prev_dout = 1'b0, prev_inv = 1'b0;

  always #4 clk = ~clk;

  rx_bitsync #(.CLK_HZ(CLK_HZ), .LOCK_W(LOCK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .bypass(bypass),
    .invert(invert), .lock_need(lock_need), .rx_raw(rx_raw),
    .data_out(data_out), .data_clk(data_clk), .locked(locked)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  // R4: retimed data checked at each clock rise, held otherwise
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      if (data_clk && !prev_clk)
        chk(data_out == (rx_raw ^ invert), "R4 mid-bit sample", data_out, rx_raw ^ invert);
      else if (invert == prev_inv)
        chk(data_out == prev_dout, "R4 hold between samples", data_out, prev_dout);
    end
    prev_clk  = data_clk;
    prev_dout = data_out;
    prev_inv  = invert;
  end

  task automatic wait_rise();
    logic p;
    do begin
      p = data_clk;
      @(negedge clk);
    end while (!(data_clk && !p));
  endtask

  task automatic send_alt(input int count, input int per);
    for (int i = 0; i < count; i++) begin
      rx_raw = ~rx_raw;
      repeat (per) @(negedge clk);
    end
  endtask

  initial begin
    int hi, lo;
    real ideal, d;
    logic [7:0] lfsr;
    logic old;

    repeat (3) @(negedge clk);
    chk(data_out == 1'b0, "R1 data_out in reset", data_out, 0);
    chk(data_clk == 1'b0, "R1 data_clk in reset", data_clk, 0);
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R8: bypass path
    bypass = 1'b1;
    for (int inv = 0; inv < 2; inv++) begin
      invert = inv[0];
      repeat (3) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
        old = rx_raw;
        rx_raw = (k == 2) ? old : ~old;
        @(negedge clk);
        chk(data_out == (old ^ invert), "R9 one edge after change", data_out, old ^ invert);
        @(negedge clk);
        chk(data_out == (rx_raw ^ invert), "R9 two edges after change", data_out, rx_raw ^ invert);
        chk(data_clk == 1'b0, "R9 clock held low", data_clk, 0);
        chk(locked == 1'b0, "R9 no lock in bypass", locked, 0);
      end
    end
    invert = 1'b0;
    #1;
    chk(data_out == rx_raw, "R8 invert off immediate", data_out, rx_raw);
    @(negedge clk);
    invert = 1'b1;
    #1;
    chk(data_out == ~rx_raw, "R8 invert on immediate", data_out, ~rx_raw);
    @(negedge clk);
    invert = 1'b0;
    bypass = 1'b0;

    // R2 / R3: free-running period and duty sweep
    for (int code = 0; code < 64; code++) begin
      rate_code = 6'(code);
      wait_rise();
      hi = 0;
      lo = 0;
      while (data_clk) begin @(negedge clk); hi++; end
      while (!data_clk) begin @(negedge clk); lo++; end
      ideal = real'(CLK_HZ) / (65574.0 * (2.0 ** (-(real'(code)) / 8.0)));
      d = real'(hi + lo) - ideal;
      chk(d < 1.5 && d > -1.5, "R2 bit period", hi + lo, $rtoi(ideal + 0.5));
      d = real'(hi) - ideal / 2.0;
      chk(d < 1.5 && d > -1.5, "R3 high time", hi, $rtoi(ideal / 2.0 + 0.5));
    end

    // R7 / R5 / R6: acquisition on preamble at code 16 (30.5 cycles per bit)
    rate_code = 6'd17;
    @(negedge clk);
    rate_code = 6'd16;
    repeat (40) @(negedge clk);
    send_alt(3, 30);
    chk(locked == 1'b0, "R6 no lock before lock_need transitions", locked, 0);
    send_alt(17, 30);
    chk(locked == 1'b1, "R5 lock after 20-bit preamble (period 30)", locked, 1);

    // R4 / R8: random data, average period 30.5
    lfsr = 8'h5b;
    mon_en = 1'b1;
    for (int i = 0; i < 48; i++) begin
      rx_raw = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (i == 24) invert = 1'b1;
      repeat ((i % 2 == 0) ? 30 : 31) @(negedge clk);
    end
    mon_en = 1'b0;
    invert = 1'b0;

    // R5 at period 31, then R6 glitch at mid-bit
    send_alt(12, 31);
    chk(locked == 1'b1, "R5 lock held on preamble (period 31)", locked, 1);
    repeat (15) @(negedge clk);
    rx_raw = ~rx_raw;
    repeat (6) @(negedge clk);
    chk(locked == 1'b0, "R6 mid-bit transition clears lock", locked, 0);
    repeat (10) @(negedge clk);
    send_alt(7, 31);
    chk(locked == 1'b0, "R6 still unlocked after 7 good transitions", locked, 0);
    send_alt(1, 31);
    chk(locked == 1'b1, "R6 relock at 8th good transition", locked, 1);

    // R7: code change unlocks
    rate_code = 6'd17;
    @(negedge clk);
    chk(locked == 1'b0, "R7 code change clears lock", locked, 0);
    rate_code = 6'd16;
    @(negedge clk);
    send_alt(20, 30);
    chk(locked == 1'b1, "R5 reacquire after code change", locked, 1);

    // R9: entering bypass drops lock and clock
    bypass = 1'b1;
    #1;
    chk(data_clk == 1'b0, "R9 clock low on bypass", data_clk, 0);
    @(negedge clk);
    chk(locked == 1'b0, "R9 lock cleared on bypass", locked, 0);

    summary();
    $finish;
  end

endmodule